// File: doc/BRIEF.md
# Windowed Chip-Select Address Decoder

This block decodes a 36-bit physical request address in two levels. The coarse level holds a bank of programmable address windows. Each window compares the upper 24 address bits against its base, with a power-of-two size field that turns the lowest base bits into don't-cares, and names a target controller. When the winning window routes the request to the external flash controller, the fine level compares the same address against one register set per chip-select line. Each set holds an 8-bit extended base that must match bits 35:28 exactly, and a 16-bit base and a 16-bit mask that apply to bits 27:12. The block then drives one active-low chip-select line.

A single flash window may span several chip-select regions, each at its own base inside the window. Software programs the registers through a one-cycle write strobe and can read any field back through a combinational read port. Every valid request produces one registered response one clock later. The response carries the target ID, the chip-select vector, window-miss and chip-select-miss flags, and a flag that reports overlapping matches.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset every window and chip-select is disabled, `rsp_valid` is low and `rsp_cs_n` is all ones, so the first request reports a window miss.
- R2: A window matches when it is enabled and `(addr[35:12] ^ {hi,lo}) & (24'hFFFFFF << size)` is zero. The response then carries that window's target ID and `rsp_win_miss` is low. When no window matches, `rsp_win_miss` is high and `rsp_tgt` is 0.
- R3: When several windows match, the lowest-numbered one supplies the target and `rsp_multi_hit` is raised.
- R4: A disabled window or chip-select never matches, whatever its base.
- R5: For a request routed to target `FLASH_TGT`, a chip-select matches only when `addr[35:28]` equals its extended base exactly and `addr[27:12] & mask` equals `base & mask`. The matching line is driven low in `rsp_cs_n`, with bit n standing for chip-select n.
- R6: Mask bits at 0 make the corresponding address bits don't-care, so one chip-select can cover a range of bases.
- R7: When several chip-selects match, only the lowest-numbered one is driven low and `rsp_multi_hit` is raised.
- R8: A flash-routed request that matches no chip-select raises `rsp_cs_miss` and leaves `rsp_cs_n` all ones.
- R9: A request routed to any other target leaves `rsp_cs_n` all ones and `rsp_cs_miss` low.
- R10: Each response is registered, so `rsp_valid` follows `req_valid` by exactly one clock and requests on back-to-back cycles each get their own response. With no request, the outputs stay idle: chip-selects all ones and no flags.
- R11: A write takes effect for the next request. The read port returns the last value written to each field. The `wr_kind`/`rd_kind` codes are: 0 window high base in [3:0], 1 window low base in [19:0], 2 window control (enable [0], target [7:4], size [12:8]), 3 chip-select extended base in [7:0], 4 chip-select base in [15:0], 5 chip-select mask in [15:0], 6 chip-select enable in [0].
- R12: `rsp_cs_n` never has more than one bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 36 | Request physical address |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Field selected for write |
| wr_idx | input | IDX_W | Window or chip-select index for write |
| wr_data | input | 32 | Write data |
| rd_kind | input | 3 | Field selected for read |
| rd_idx | input | IDX_W | Window or chip-select index for read |
| rd_data | output | 32 | Read data, combinational |
| rsp_valid | output | 1 | Response present |
| rsp_tgt | output | TGT_W | Target ID of the winning window |
| rsp_win_miss | output | 1 | No window matched |
| rsp_cs_n | output | NUM_CS | Active-low chip-select lines |
| rsp_cs_miss | output | 1 | Flash-routed request with no chip-select match |
| rsp_multi_hit | output | 1 | More than one window or chip-select matched |

## Verification
The hardest situation to reach from the ports is a request whose extended-base compare alone decides the chip-select. The masked compare of a lower-numbered line would also pass, so a decoder that dropped the exact 8-bit check would still answer, but with the wrong line. The stimulus programs chip-select 0 with a wrong extended base and chip-select 3 with the right one, both with the same masked base, and sends an address inside both masked ranges. It then uses enable and disable writes between requests to walk the same address through overlapping-window, single-window, non-flash and miss outcomes.

// File: rtl/cs_window_decoder.sv
module cs_window_decoder #(
  parameter int NUM_WIN = 8,
  parameter int NUM_CS = 8,
  parameter int TGT_W = 4,
  parameter logic [TGT_W-1:0] FLASH_TGT = 3,
  parameter int IDX_W = $clog2(NUM_WIN > NUM_CS ? NUM_WIN : NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [35:0]       req_addr,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_kind,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  output logic              rsp_valid,
  output logic [TGT_W-1:0]  rsp_tgt,
  output logic              rsp_win_miss,
  output logic [NUM_CS-1:0] rsp_cs_n,
  output logic              rsp_cs_miss,
  output logic              rsp_multi_hit
);
  localparam logic [2:0] K_WHI = 3'd0, K_WLO = 3'd1, K_WCTL = 3'd2,
                         K_CEXT = 3'd3, K_CBASE = 3'd4, K_CMASK = 3'd5, K_CEN = 3'd6;

  logic [3:0]       win_hi   [NUM_WIN];
  logic [19:0]      win_lo   [NUM_WIN];
  logic [TGT_W-1:0] win_tgt  [NUM_WIN];
  logic [4:0]       win_size [NUM_WIN];
  logic [NUM_WIN-1:0] win_en;
  logic [7:0]       cs_ext   [NUM_CS];
  logic [15:0]      cs_base  [NUM_CS];
  logic [15:0]      cs_mask  [NUM_CS];
  logic [NUM_CS-1:0] cs_en;

  logic [NUM_WIN-1:0] win_vec;
  logic [NUM_CS-1:0]  cs_vec, cs_first;
  logic [TGT_W-1:0]   sel_tgt;
  logic win_any, to_flash, multi;
  logic unused_bits;

  assign unused_bits = ^{wr_data, req_addr[11:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en <= '0;
      cs_en  <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        win_hi[i] <= '0; win_lo[i] <= '0; win_tgt[i] <= '0; win_size[i] <= '0;
      end
      for (int j = 0; j < NUM_CS; j++) begin
        cs_ext[j] <= '0; cs_base[j] <= '0; cs_mask[j] <= '0;
      end
    end else if (wr_en) begin
      if (int'(wr_idx) < NUM_WIN) begin
        case (wr_kind)
          K_WHI:  win_hi[wr_idx] <= wr_data[3:0];
          K_WLO:  win_lo[wr_idx] <= wr_data[19:0];
          K_WCTL: begin
            win_en[wr_idx]   <= wr_data[0];
            win_tgt[wr_idx]  <= wr_data[4 +: TGT_W];
            win_size[wr_idx] <= wr_data[12:8];
          end
          default: ;
        endcase
      end
      if (int'(wr_idx) < NUM_CS) begin
        case (wr_kind)
          K_CEXT:  cs_ext[wr_idx]  <= wr_data[7:0];
          K_CBASE: cs_base[wr_idx] <= wr_data[15:0];
          K_CMASK: cs_mask[wr_idx] <= wr_data[15:0];
          K_CEN:   cs_en[wr_idx]   <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign win_vec[i] = win_en[i] &&
      (((req_addr[35:12] ^ {win_hi[i], win_lo[i]}) & (24'hFF_FFFF << win_size[i])) == 24'd0);
  end

  for (genvar j = 0; j < NUM_CS; j++) begin : g_cs
    assign cs_vec[j] = cs_en[j] && (req_addr[35:28] == cs_ext[j]) &&
      (((req_addr[27:12] ^ cs_base[j]) & cs_mask[j]) == 16'd0);
  end

  always_comb begin
    sel_tgt = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (win_vec[i]) sel_tgt = win_tgt[i];
  end

  assign win_any  = |win_vec;
  assign to_flash = win_any && (sel_tgt == FLASH_TGT);
  assign cs_first = cs_vec & (~cs_vec + 1'b1);
  assign multi    = ((win_vec & (win_vec - 1'b1)) != '0) ||
                    (to_flash && ((cs_vec & (cs_vec - 1'b1)) != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_tgt       <= '0;
      rsp_win_miss  <= 1'b0;
      rsp_cs_n      <= '1;
      rsp_cs_miss   <= 1'b0;
      rsp_multi_hit <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_tgt       <= (req_valid && win_any) ? sel_tgt : '0;
      rsp_win_miss  <= req_valid && !win_any;
      rsp_cs_n      <= (req_valid && to_flash) ? ~cs_first : '1;
      rsp_cs_miss   <= req_valid && to_flash && (cs_vec == '0);
      rsp_multi_hit <= req_valid && multi;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < NUM_WIN) begin
      case (rd_kind)
        K_WHI:  rd_data = 32'(win_hi[rd_idx]);
        K_WLO:  rd_data = 32'(win_lo[rd_idx]);
        K_WCTL: rd_data = (32'(win_size[rd_idx]) << 8) | (32'(win_tgt[rd_idx]) << 4) |
                          32'(win_en[rd_idx]);
        default: ;
      endcase
    end
    if (int'(rd_idx) < NUM_CS) begin
      case (rd_kind)
        K_CEXT:  rd_data = 32'(cs_ext[rd_idx]);
        K_CBASE: rd_data = 32'(cs_base[rd_idx]);
        K_CMASK: rd_data = 32'(cs_mask[rd_idx]);
        K_CEN:   rd_data = 32'(cs_en[rd_idx]);
        default: ;
      endcase
    end
  end
endmodule

module cs_window_decoder_chk #(
  parameter int NUM_CS = 8,
  parameter int TGT_W = 4,
  parameter logic [TGT_W-1:0] FLASH_TGT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [TGT_W-1:0]  rsp_tgt,
  input logic              rsp_win_miss,
  input logic [NUM_CS-1:0] rsp_cs_n,
  input logic              rsp_cs_miss,
  input logic              rsp_multi_hit
);
  a_r12_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~rsp_cs_n));

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_cs_n == '1 && !rsp_win_miss && !rsp_cs_miss && !rsp_multi_hit));

  a_r8_miss_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cs_miss |-> (rsp_cs_n == '1 && rsp_tgt == FLASH_TGT && !rsp_win_miss));

  a_r2_win_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_win_miss |-> (rsp_tgt == '0 && rsp_cs_n == '1 && !rsp_cs_miss));

  a_r9_other_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_win_miss && rsp_tgt != FLASH_TGT) |-> (rsp_cs_n == '1 && !rsp_cs_miss));
endmodule

bind cs_window_decoder cs_window_decoder_chk #(
  .NUM_CS(NUM_CS), .TGT_W(TGT_W), .FLASH_TGT(FLASH_TGT)
) u_chk (.*);

// File: tb/test_cs_window_decoder.sv
module test_cs_window_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [35:0] req_addr = '0;
  logic        wr_en = 0;
  logic [2:0]  wr_kind = '0, rd_kind = '0;
  logic [2:0]  wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        rsp_valid, rsp_win_miss, rsp_cs_miss, rsp_multi_hit;
  logic [3:0]  rsp_tgt;
  logic [7:0]  rsp_cs_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [14:0] exp_q[$];
  string       tag_q[$];

  cs_window_decoder i_cs_window_decoder (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [14:0] ex(bit multi, bit cmiss, logic [7:0] csn, bit wmiss, logic [3:0] tgt);
    return {multi, cmiss, csn, wmiss, tgt};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [35:0] a, logic [14:0] e, string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wr(logic [2:0] k, logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    req_valid = 0; wr_en = 1; wr_kind = k; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(logic [2:0] k, logic [2:0] idx, logic [31:0] exp, string tag);
    rd_kind = k; rd_idx = idx; #1;
    check(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected response", 1, 0);
      else begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, {17'd0, rsp_multi_hit, rsp_cs_miss, rsp_cs_n, rsp_win_miss, rsp_tgt}, {17'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle cs_n after reset", rsp_cs_n, 8'hFF);
    check("R1 idle valid after reset", rsp_valid, 0);
    rd_chk(3'd2, 3'd0, 0, "R1 window 0 disabled at reset");
    send(36'h0_0000_0000, ex(0, 0, 8'hFF, 1, 0), "R1 first request misses");
    idle();

    wr(3'd0, 0, 32'hF); wr(3'd1, 0, 32'hF0000); wr(3'd2, 0, 32'h1031);
    wr(3'd0, 1, 32'h0); wr(3'd1, 1, 32'h0);     wr(3'd2, 1, 32'h1411);
    wr(3'd3, 0, 32'hFE); wr(3'd4, 0, 32'hE000); wr(3'd5, 0, 32'hF000); wr(3'd6, 0, 1);
    wr(3'd3, 1, 32'hFF); wr(3'd4, 1, 32'hC000); wr(3'd5, 1, 32'hE000); wr(3'd6, 1, 1);
    wr(3'd3, 2, 32'hFF); wr(3'd4, 2, 32'hC000); wr(3'd5, 2, 32'hF000); wr(3'd6, 2, 1);
    wr(3'd3, 3, 32'hFF); wr(3'd4, 3, 32'hE000); wr(3'd5, 3, 32'hF000); wr(3'd6, 3, 1);

    send(36'h0_1234_5678, ex(0, 0, 8'hFF, 0, 1), "R2 R9 non-flash window hit");
    send(36'hF_FE00_0000, ex(0, 0, 8'hF7, 0, 3), "R5 exact extended base picks cs3");
    send(36'hF_FD12_3456, ex(0, 0, 8'hFD, 0, 3), "R6 masked bits ignored cs1");
    send(36'hF_FC00_0000, ex(1, 0, 8'hFD, 0, 3), "R7 lowest cs wins multi");
    send(36'hF_F000_0000, ex(0, 1, 8'hFF, 0, 3), "R8 flash no cs match");
    send(36'h1_0000_0000, ex(0, 0, 8'hFF, 1, 0), "R2 R10 back-to-back window miss");
    idle();
    @(negedge clk);
    check("R10 idle after burst", {rsp_valid, rsp_cs_n}, {1'b0, 8'hFF});

    wr(3'd0, 2, 32'h0); wr(3'd1, 2, 32'h0); wr(3'd2, 2, 32'h1421);
    send(36'h0_1234_5678, ex(1, 0, 8'hFF, 0, 1), "R3 lowest window wins multi");
    wr(3'd2, 1, 32'h1410);
    send(36'h0_1234_5678, ex(0, 0, 8'hFF, 0, 2), "R4 R11 disabled window skipped next request");
    rd_chk(3'd2, 3'd1, 32'h1410, "R11 window ctl readback");
    wr(3'd2, 2, 32'h1420);
    send(36'h0_1234_5678, ex(0, 0, 8'hFF, 1, 0), "R4 all windows disabled");
    wr(3'd6, 3, 0);
    send(36'hF_FE00_0000, ex(0, 1, 8'hFF, 0, 3), "R4 disabled cs never matches");
    wr(3'd3, 0, 32'hFF);
    send(36'hF_FE00_0000, ex(0, 0, 8'hFE, 0, 3), "R5 cs0 after ext fix");
    wr(3'd2, 0, 32'h1030);
    wr(3'd0, 3, 32'hF); wr(3'd1, 3, 32'hF0000); wr(3'd2, 3, 32'h1051);
    send(36'hF_FE00_0000, ex(0, 0, 8'hFF, 0, 5), "R9 other target no cs");
    idle();

    rd_chk(3'd1, 3'd3, 32'hF0000, "R11 window low readback");
    rd_chk(3'd0, 3'd0, 32'hF, "R11 window high readback");
    rd_chk(3'd5, 3'd1, 32'hE000, "R11 cs mask readback");
    rd_chk(3'd3, 3'd0, 32'hFF, "R11 cs ext readback");
    rd_chk(3'd4, 3'd2, 32'hC000, "R11 cs base readback");
    rd_chk(3'd6, 3'd3, 32'h0, "R11 cs enable readback");

    repeat (3) @(negedge clk);
    check("R10 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule